// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns two encoder signals into a signed-free position count held between two programmable limits. Each of the two input lines is first synchronised, then optionally inverted, then optionally passed through a glitch filter with its own hold length. The cleaned pair is decoded in one of two ways. In phase mode it is read as a quadrature pair: every legal edge on either line moves the count by one, four counts per encoder cycle. In count/direction mode one line acts as the step clock and the other gives the direction.

The count runs between a low limit and a high limit and wraps from one to the other. A sticky overflow flag marks every wrap. A companion bit says whether the latest wrap went past the top or the bottom of the range. A clear input reloads the count with the low limit. The block suits motor-position feedback, where the limits match one mechanical revolution and the flags let firmware keep a revolution tally.

Top module: `quad_pos_counter`

## Requirements
- R1: In phase mode (`mode`=0) each change of exactly one decoded line moves the count by one. The decoded pair {A,B} stepping through 00,10,11,01,00 counts up, and the reverse order counts down. This gives four counts per cycle.
- R2: In phase mode, a change of both decoded lines between two consecutive samples is ignored and leaves the count unchanged.
- R3: In count/direction mode (`mode`=1) each rising edge of decoded A moves the count by one: up when decoded B is 1, down when it is 0. Changes of B alone do not step.
- R4: `inv_a` and `inv_b` invert their line before filtering and decoding. Inverting one line in phase mode reverses the counting direction. Inverting both leaves it unchanged.
- R5: With a line's filter enabled, a new level is accepted only after it has held for `filt_val`+1 consecutive clock cycles, and shorter pulses are dropped. With the filter disabled, the line passes through with no hold requirement.
- R6: Counting up from `lim_hi` loads `lim_lo`, and counting down from `lim_lo` loads `lim_hi`. Every other step changes the count by exactly one.
- R7: `dir_up` shows the direction of the most recent step: 1 for up, 0 for down.
- R8: `ovf` is set by every wrap and stays set until `ovf_clr` is high at a clock edge. A wrap in the same cycle as the clear wins.
- R9: `ovf_top` becomes 1 on a wrap past the top and 0 on a wrap past the bottom, and holds between wraps.
- R10: `clr` loads `lim_lo` into the count at the next clock edge and leaves `ovf` and `ovf_top` unchanged.
- R11: After reset, the count, `dir_up`, `ovf` and `ovf_top` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 phase decode, 1 count/direction decode |
| inv_a | input | 1 | Invert line A |
| inv_b | input | 1 | Invert line B |
| filt_en_a | input | 1 | Enable filter on line A |
| filt_en_b | input | 1 | Enable filter on line B |
| filt_val_a | input | FW | Hold length for line A |
| filt_val_b | input | FW | Hold length for line B |
| lim_lo | input | CW | Low count limit |
| lim_hi | input | CW | High count limit |
| in_a | input | 1 | Encoder line A (asynchronous) |
| in_b | input | 1 | Encoder line B (asynchronous) |
| clr | input | 1 | Load low limit into count |
| ovf_clr | input | 1 | Clear overflow flag |
| count | output | CW | Position count |
| dir_up | output | 1 | Direction of last step |
| ovf | output | 1 | Sticky wrap flag |
| ovf_top | output | 1 | Last wrap was past the top |

## Verification
The assertions take for granted that `lim_lo` is not above `lim_hi` and that both limits stay fixed while the counter runs. Under that condition, a flag that rises always sits beside a count equal to one of the limits. The stimulus sets the limits once, before the first clear, and never changes them. Configuration changes are made only while both lines are idle and are always followed by a settling wait and a clear, so stray steps caused by flipping an inversion bit never reach a check.

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int CW = 16,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          inv_a,
  input  logic          inv_b,
  input  logic          filt_en_a,
  input  logic          filt_en_b,
  input  logic [FW-1:0] filt_val_a,
  input  logic [FW-1:0] filt_val_b,
  input  logic [CW-1:0] lim_lo,
  input  logic [CW-1:0] lim_hi,
  input  logic          in_a,
  input  logic          in_b,
  input  logic          clr,
  input  logic          ovf_clr,
  output logic [CW-1:0] count,
  output logic          dir_up,
  output logic          ovf,
  output logic          ovf_top
);

  logic [1:0] sync1, sync2, dec, flt, prv, fen;
  logic [FW-1:0] fval [2];

  assign dec = sync2 ^ {inv_b, inv_a};
  assign fen = {filt_en_b, filt_en_a};
  assign fval[0] = filt_val_a;
  assign fval[1] = filt_val_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prv   <= '0;
    end else begin
      sync1 <= {in_b, in_a};
      sync2 <= sync1;
      prv   <= flt;
    end

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [FW-1:0] hold;
    logic          lvl;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        hold <= '0;
        lvl  <= 1'b0;
      end else if (!fen[g] || dec[g] == lvl) begin
        hold <= '0;
        lvl  <= dec[g];
      end else if (hold >= fval[g]) begin
        hold <= '0;
        lvl  <= dec[g];
      end else begin
        hold <= hold + 1'b1;
      end
    assign flt[g] = lvl;
  end

  logic [1:0] chg;
  logic ab_step, ab_up, cd_step, step, up;

  assign chg     = flt ^ prv;
  assign ab_step = (chg == 2'b01) || (chg == 2'b10);
  assign ab_up   = chg[0] ? (flt[0] ^ flt[1]) : ~(flt[0] ^ flt[1]);
  assign cd_step = flt[0] & ~prv[0];
  assign step    = mode ? cd_step : ab_step;
  assign up      = mode ? flt[1] : ab_up;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count   <= '0;
      dir_up  <= 1'b0;
      ovf     <= 1'b0;
      ovf_top <= 1'b0;
    end else begin
      if (ovf_clr) ovf <= 1'b0;
      if (clr) begin
        count <= lim_lo;
      end else if (step) begin
        dir_up <= up;
        if (up) begin
          if (count == lim_hi) begin
            count   <= lim_lo;
            ovf     <= 1'b1;
            ovf_top <= 1'b1;
          end else begin
            count <= count + 1'b1;
          end
        end else begin
          if (count == lim_lo) begin
            count   <= lim_hi;
            ovf     <= 1'b1;
            ovf_top <= 1'b0;
          end else begin
            count <= count - 1'b1;
          end
        end
      end
    end

endmodule

// File: rtl/quad_pos_counter_chk.sv
module quad_pos_counter_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          ovf_clr,
  input logic [CW-1:0] lim_lo,
  input logic [CW-1:0] lim_hi,
  input logic [CW-1:0] count,
  input logic          ovf,
  input logic          ovf_top
);

  // R10
  clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == $past(lim_lo));

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);

  // R9
  wrap_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> (ovf_top && count == lim_lo) || (!ovf_top && count == lim_hi));

  // R6
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> count == $past(count) || count == CW'($past(count) + 1'b1) ||
             count == CW'($past(count) - 1'b1) || count == lim_lo || count == lim_hi);

endmodule

bind quad_pos_counter quad_pos_counter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ovf_clr(ovf_clr),
  .lim_lo(lim_lo), .lim_hi(lim_hi), .count(count), .ovf(ovf), .ovf_top(ovf_top)
);

// File: tb/sim_quad_pos_counter.sv
`timescale 1ns/1ps
module sim_quad_pos_counter;
  localparam int CW = 16;
  localparam int FW = 4;
  localparam int LO = 3;
  localparam int HI = 10;

  logic clk = 0, rst_n = 0;
  logic mode = 0, inv_a = 0, inv_b = 0, filt_en_a = 0, filt_en_b = 0;
  logic [FW-1:0] filt_val_a = '0, filt_val_b = '0;
  logic [CW-1:0] lim_lo = CW'(LO), lim_hi = CW'(HI);
  logic in_a = 0, in_b = 0, clr = 0, ovf_clr = 0;
  logic [CW-1:0] count;
  logic dir_up, ovf, ovf_top;

  always #4 clk = ~clk;

  quad_pos_counter #(.CW(CW), .FW(FW)) u0 (.*);

  int total = 0, bad = 0, cyc = 0;
  int exp_cnt = 0, exp_ovf = 0, exp_top = 0, exp_dir = 0;
  bit top_ok = 0, dir_ok = 0, done = 0;
  logic [1:0] idx = 0;

  task automatic check(string tag, int act, int expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model(bit up);
    exp_dir = up; dir_ok = 1;
    if (up) begin
      if (exp_cnt == HI) begin exp_cnt = LO; exp_ovf = 1; exp_top = 1; top_ok = 1; end
      else exp_cnt++;
    end else begin
      if (exp_cnt == LO) begin exp_cnt = HI; exp_ovf = 1; exp_top = 0; top_ok = 1; end
      else exp_cnt--;
    end
  endtask

  task automatic observe(string tag);
    check({tag, " R6 count"}, int'(count), exp_cnt);
    check({tag, " R8 ovf"}, int'(ovf), exp_ovf);
    if (top_ok) check({tag, " R9 ovf_top"}, int'(ovf_top), exp_top);
    if (dir_ok) check({tag, " R7 dir_up"}, int'(dir_up), exp_dir);
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
  endtask

  task automatic pulse_ovf_clr();
    @(negedge clk) ovf_clr = 1;
    @(negedge clk) ovf_clr = 0;
  endtask

  task automatic settle();
    waitc(12);
    pulse_clr();
    pulse_ovf_clr();
    exp_cnt = LO; exp_ovf = 0; top_ok = 0; dir_ok = 0;
  endtask

  task automatic ab_edge(bit fwd, string tag);
    idx = fwd ? idx + 2'd1 : idx - 2'd1;
    case (idx)
      2'd0: {in_a, in_b} = 2'b00;
      2'd1: {in_a, in_b} = 2'b10;
      2'd2: {in_a, in_b} = 2'b11;
      default: {in_a, in_b} = 2'b01;
    endcase
    waitc(8);
    model(fwd ^ inv_a ^ inv_b);
    observe(tag);
  endtask

  task automatic cd_pulse(int width, bit counts, bit up, string tag);
    in_a = 1; waitc(width);
    in_a = 0; waitc(12);
    if (counts) model(up);
    observe(tag);
  endtask

  initial begin
    waitc(3);
    check("R11 count", int'(count), 0);
    check("R11 dir_up", int'(dir_up), 0);
    check("R11 ovf", int'(ovf), 0);
    check("R11 ovf_top", int'(ovf_top), 0);
    rst_n = 1;
    waitc(4);
    pulse_clr(); waitc(1);
    exp_cnt = LO;
    check("R10 clr loads low limit", int'(count), LO);
    check("R10 flags untouched", int'(ovf), 0);

    for (int i = 0; i < 26; i++) ab_edge(1'b1, "R1 fwd");
    pulse_ovf_clr(); exp_ovf = 0;
    check("R8 ovf cleared", int'(ovf), 0);
    check("R9 ovf_top held", int'(ovf_top), 1);
    for (int i = 0; i < 26; i++) ab_edge(1'b0, "R1 rev");

    pulse_clr(); waitc(1); exp_cnt = LO;
    check("R10 clr keeps ovf", int'(ovf), exp_ovf);
    for (int i = 0; i < 3; i++) ab_edge(1'b1, "R1 pre");
    idx = idx + 2'd2;
    {in_a, in_b} = ~{in_a, in_b};
    waitc(8);
    check("R2 double change ignored", int'(count), exp_cnt);
    for (int i = 0; i < 5; i++) ab_edge(1'b1, "R2 resume");

    {in_a, in_b} = 2'b00; idx = 0; inv_a = 1;
    settle();
    for (int i = 0; i < 12; i++) ab_edge(1'b1, "R4 inv_a");
    inv_b = 1;
    settle();
    for (int i = 0; i < 12; i++) ab_edge(1'b1, "R4 inv_both");

    {in_a, in_b} = 2'b00; idx = 0; inv_a = 0; inv_b = 0; mode = 1;
    settle();
    in_b = 1;
    for (int i = 0; i < 10; i++) cd_pulse(8, 1'b1, 1'b1, "R3 up");
    in_b = 0;
    for (int i = 0; i < 10; i++) cd_pulse(8, 1'b1, 1'b0, "R3 down");
    for (int i = 0; i < 3; i++) begin
      in_b = 1; waitc(10); in_b = 0; waitc(10);
      observe("R3 B alone");
    end
    inv_b = 1;
    settle();
    for (int i = 0; i < 4; i++) cd_pulse(8, 1'b1, 1'b1, "R4 inv_b count/dir");
    inv_b = 0; in_b = 1;
    settle();

    cd_pulse(3, 1'b1, 1'b1, "R5 no filter short pulse");
    filt_en_a = 1; filt_val_a = 4'd5;
    waitc(10);
    cd_pulse(3, 1'b0, 1'b1, "R5 short pulse dropped");
    cd_pulse(5, 1'b0, 1'b1, "R5 5-cycle pulse dropped");
    cd_pulse(12, 1'b1, 1'b1, "R5 long pulse accepted");
    filt_en_a = 0;
    waitc(10);

    in_b = 0; waitc(1); in_a = 1; waitc(2); in_b = 1; waitc(12); in_a = 0; waitc(12);
    model(1'b0); observe("R5 unfiltered B glitch");
    filt_en_b = 1; filt_val_b = 4'd5;
    waitc(10);
    in_b = 0; waitc(1); in_a = 1; waitc(2); in_b = 1; waitc(12); in_a = 0; waitc(12);
    model(1'b1); observe("R5 filtered B glitch");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule